// File: doc/BRIEF.md
# Layered Pixel Compositor

This block merges up to four streams of 8-bit ARGB pixels into a single output stream, one output pixel per clock. It works over a rectangular output window whose width and height are programmable, and it starts from a programmable background colour. Each layer comes in on its own valid/ready stream, already unpacked. Each layer can be switched on or off, and each layer chooses how it is blended. The output is an ARGB valid/ready stream. The pixel that closes the window carries an end-of-frame flag.

Software programs the block through a plain word-wide register port. It can start and stop compositing, hold the pipeline at the top of a frame with a soft reset, and receive an interrupt when a whole window has left the block. An output pixel is produced only when every enabled layer offers a pixel and the output register has room. The output register has room when it is empty or when its pixel is being taken in the same cycle. All enabled layers are consumed together in that cycle. A disabled layer is never consumed. A pixel presented on the output stays unchanged until the sink raises `out_ready`. The parameter `NUM_LAYERS` selects the four-layer build or a two-layer build.

Top module: `layer_compositor`

## Requirements
- R1: After reset, `out_valid`, `irq`, `out_last` and every bit of `lyr_ready` are low, and every register reads back zero.
- R2: The output stream holds `out_pix`/`out_last` stable while `out_valid` is high and `out_ready` is low. The enabled layers are consumed, with all their `lyr_ready` bits high in one cycle, only when the output register is empty or is being drained in that cycle. The result appears on the output one cycle after consumption.
- R3: The source-enable register (address 0x18) holds one bit per layer, and bit i selects layer i. A layer whose bit is clear keeps its `lyr_ready` low and does not change the composite.
- R4: In coverage mode (layer control bit 9 = 0), each colour channel becomes round((src·a + dst·(255−a))/255).
- R5: In premultiplied mode (layer control bit 9 = 1), each colour channel becomes min(255, src' + round(dst·(255−a)/255)). Here src' is round(src·K/255) when the constant alpha is enabled, and src otherwise.
- R6: The layer control word (address 0x40+8·i) holds a constant alpha K in bits 7:0 and an alpha-enable bit at bit 8. With the enable set, the effective alpha is a = round(K·p/255), where p is the pixel alpha. With the enable clear, a = p. Pixels are ARGB, with A in bits 31:24, R in 23:16, G in 15:8 and B in 7:0.
- R7: Bit 28 of the layer mode word (address 0x44+8·i) is the constant-blend flag. When it is set, the pixel's own alpha is ignored and p is taken as 255.
- R8: Layer 0 is blended onto the background first, and each higher layer is blended on top of the result in ascending order.
- R9: With a background alpha of 255, the output alpha byte is 255. With any other background alpha (register 0x14, alpha in bits 31:24), the output equals the background word whatever the layers hold.
- R10: The window size register (0x10) holds the height in bits 31:16 and the width in bits 15:0. Output pixels run in raster order. `out_last` is high only on the pixel at column width−1, row height−1.
- R11: The frame-complete status (0x0C, bit 0) is set in the cycle after the last pixel of a window is accepted, and writing zero to it clears it. Writing any other value leaves it unchanged. `irq` is the status ANDed with bit 1 of the interrupt-enable register (0x08).
- R12: While the soft-reset register (0x04, bit 0) holds 1, no layer is consumed and a pending output pixel is dropped. After it is written back to 0, the next pixel is at the start of a frame.
- R13: Compositing runs only while bit 0 of the run register (0x00) is 1. While it is 0, no layer is consumed and no new output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lyr_valid | input | NUM_LAYERS | Per-layer pixel valid |
| lyr_ready | output | NUM_LAYERS | Per-layer pixel accept |
| lyr_pix | input | 32·NUM_LAYERS | ARGB pixels, layer i in bits 32i+31:32i |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output sink ready |
| out_pix | output | 32 | Composite ARGB pixel |
| out_last | output | 1 | Last pixel of the window |
| irq | output | 1 | Frame-complete interrupt |

## Verification
The properties assume that the window size is nonzero and is not changed partway through a frame. They also assume that the status bit only rises because a pixel flagged as last has left the output. The hold property leaves out cycles in which a soft reset is already active, because flushing the output in those cycles is legal. The bench therefore changes window size, layer modes and enables only while every layer valid is low, and realigns the raster with a soft-reset pulse before each frame-level check.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int PIX_W  = 32;
  localparam int DIM_W  = 16;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_RUN      = 8'h00;
  localparam logic [ADDR_W-1:0] A_SRST     = 8'h04;
  localparam logic [ADDR_W-1:0] A_IEN      = 8'h08;
  localparam logic [ADDR_W-1:0] A_ISTAT    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_ROI      = 8'h10;
  localparam logic [ADDR_W-1:0] A_BG       = 8'h14;
  localparam logic [ADDR_W-1:0] A_SRCEN    = 8'h18;
  localparam logic [ADDR_W-1:0] A_LYR_BASE = 8'h40;
  localparam int LYR_STRIDE = 8;
  localparam int IEN_BIT    = 1;
  localparam int CBLEND_BIT = 28;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  typedef struct packed {
    logic       premul;
    logic       cblend;
    logic       aen;
    logic [7:0] calpha;
  } lyr_cfg_t;

  // x / 255 rounded to nearest, exact for x <= 255*255
  function automatic logic [7:0] div255(input logic [15:0] x);
    logic [16:0] t;
    t = {1'b0, x} + 17'd128;
    t = t + (t >> 8);
    return t[15:8];
  endfunction

  function automatic logic [15:0] mul8(input logic [7:0] a, input logic [7:0] b);
    return 16'(a) * 16'(b);
  endfunction
endpackage

// File: rtl/lc_regs.sv
module lc_regs
  import lc_pkg::*;
#(
  parameter int NL = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  frame_done,
  output logic                  run_en,
  output logic                  srst_on,
  output logic                  irq_stat,
  output logic                  irq,
  output logic [DIM_W-1:0]      roi_w,
  output logic [DIM_W-1:0]      roi_h,
  output argb_t                 bg,
  output logic [NL-1:0]         src_en,
  output lyr_cfg_t [NL-1:0]     cfg
);
  logic        ien_q;
  logic [31:0] roi_q;
  logic [9:0]  ctl_q [NL];
  logic        cb_q  [NL];

  assign roi_w = roi_q[DIM_W-1:0];
  assign roi_h = roi_q[31:16];
  assign irq   = irq_stat & ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      srst_on  <= 1'b0;
      ien_q    <= 1'b0;
      irq_stat <= 1'b0;
      roi_q    <= '0;
      bg       <= '0;
      src_en   <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_RUN:   run_en  <= wdata[0];
          A_SRST:  srst_on <= wdata[0];
          A_IEN:   ien_q   <= wdata[IEN_BIT];
          A_ROI:   roi_q   <= wdata;
          A_BG:    bg      <= wdata;
          A_SRCEN: src_en  <= wdata[NL-1:0];
          default: ;
        endcase
      end
      if (frame_done)
        irq_stat <= 1'b1;
      else if (we && addr == A_ISTAT && wdata == 32'd0)
        irq_stat <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < NL; gi++) begin : g_lyr
    localparam logic [ADDR_W-1:0] CTL_A = A_LYR_BASE + ADDR_W'(gi * LYR_STRIDE);
    localparam logic [ADDR_W-1:0] MOD_A = CTL_A + ADDR_W'(4);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[gi] <= '0;
        cb_q[gi]  <= 1'b0;
      end else if (we) begin
        if (addr == CTL_A) ctl_q[gi] <= wdata[9:0];
        if (addr == MOD_A) cb_q[gi]  <= wdata[CBLEND_BIT];
      end
    end
    assign cfg[gi] = {ctl_q[gi][9], cb_q[gi], ctl_q[gi][8], ctl_q[gi][7:0]};
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RUN:   rdata = {31'd0, run_en};
      A_SRST:  rdata = {31'd0, srst_on};
      A_IEN:   rdata = 32'(ien_q) << IEN_BIT;
      A_ISTAT: rdata = {31'd0, irq_stat};
      A_ROI:   rdata = roi_q;
      A_BG:    rdata = bg;
      A_SRCEN: rdata = 32'(src_en);
      default: ;
    endcase
    for (int i = 0; i < NL; i++) begin
      if (addr == A_LYR_BASE + ADDR_W'(i * LYR_STRIDE))
        rdata = {22'd0, ctl_q[i]};
      if (addr == A_LYR_BASE + ADDR_W'(i * LYR_STRIDE + 4))
        rdata = 32'(cb_q[i]) << CBLEND_BIT;
    end
  end
endmodule

// File: rtl/lc_blend_stage.sv
module lc_blend_stage
  import lc_pkg::*;
(
  input  argb_t    dst,
  input  argb_t    src,
  input  lyr_cfg_t cfg,
  input  logic     en,
  output argb_t    res
);
  logic [7:0] pix_a;
  logic [7:0] eff_a;
  logic [7:0] inv_a;

  function automatic logic [7:0] mix(input logic [7:0] s, input logic [7:0] d,
                                     input logic [7:0] a, input logic [7:0] ia,
                                     input lyr_cfg_t c);
    logic [7:0] sp;
    logic [8:0] sum;
    if (c.premul) begin
      sp  = c.aen ? div255(mul8(s, c.calpha)) : s;
      sum = {1'b0, sp} + {1'b0, div255(mul8(d, ia))};
      return sum[8] ? 8'hFF : sum[7:0];
    end
    return div255(mul8(s, a) + mul8(d, ia));
  endfunction

  always_comb begin
    pix_a = cfg.cblend ? 8'hFF : src.a;
    eff_a = cfg.aen ? div255(mul8(cfg.calpha, pix_a)) : pix_a;
    inv_a = ~eff_a;
    res   = dst;
    if (en) begin
      res.r = mix(src.r, dst.r, eff_a, inv_a, cfg);
      res.g = mix(src.g, dst.g, eff_a, inv_a, cfg);
      res.b = mix(src.b, dst.b, eff_a, inv_a, cfg);
    end
  end
endmodule

// File: rtl/lc_raster.sv
module lc_raster
  import lc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  output logic             at_last
);
  logic [DIM_W-1:0] col_q;
  logic [DIM_W-1:0] row_q;
  logic             row_end;
  logic             col_end;

  assign col_end = (col_q == width - DIM_W'(1));
  assign row_end = (row_q == height - DIM_W'(1));
  assign at_last = col_end && row_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (clear) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv) begin
      if (col_end) begin
        col_q <= '0;
        row_q <= row_end ? '0 : row_q + DIM_W'(1);
      end else begin
        col_q <= col_q + DIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import lc_pkg::*;
#(
  parameter int NUM_LAYERS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [7:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic [NUM_LAYERS-1:0]       lyr_valid,
  output logic [NUM_LAYERS-1:0]       lyr_ready,
  input  logic [NUM_LAYERS*32-1:0]    lyr_pix,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [31:0]                 out_pix,
  output logic                        out_last,
  output logic                        irq
);
  localparam int NL = NUM_LAYERS;

  logic                 run_en;
  logic                 srst_on;
  logic                 irq_stat;
  logic [DIM_W-1:0]     roi_w;
  logic [DIM_W-1:0]     roi_h;
  argb_t                bg;
  logic [NL-1:0]        src_en;
  lyr_cfg_t [NL-1:0]    cfg;
  logic                 frame_done;
  logic                 at_last;
  logic                 fire;
  logic                 inputs_ok;
  logic                 has_room;
  argb_t                chain [NL+1];
  argb_t                comp;

  lc_regs #(.NL(NL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_done(frame_done), .run_en(run_en), .srst_on(srst_on),
    .irq_stat(irq_stat), .irq(irq), .roi_w(roi_w), .roi_h(roi_h), .bg(bg),
    .src_en(src_en), .cfg(cfg)
  );

  assign inputs_ok = &(lyr_valid | ~src_en);
  assign has_room  = !out_valid || out_ready;
  assign fire      = run_en && !srst_on && inputs_ok && has_room;
  assign lyr_ready = fire ? src_en : '0;

  lc_raster u_raster (
    .clk(clk), .rst_n(rst_n), .clear(srst_on), .adv(fire),
    .width(roi_w), .height(roi_h), .at_last(at_last)
  );

  assign chain[0] = bg;
  for (genvar gi = 0; gi < NL; gi++) begin : g_blend
    lc_blend_stage u_stage (
      .dst(chain[gi]), .src(lyr_pix[gi*PIX_W +: PIX_W]), .cfg(cfg[gi]),
      .en(src_en[gi]), .res(chain[gi+1])
    );
  end

  always_comb begin
    if (bg.a == 8'hFF) begin
      comp   = chain[NL];
      comp.a = 8'hFF;
    end else begin
      comp = bg;
    end
  end

  assign frame_done = out_valid && out_ready && out_last && !srst_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
    end else if (srst_on) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_pix   <= comp;
      out_last  <= at_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] lyr_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_pix,
  input logic          out_last,
  input logic          run_en,
  input logic          srst_on,
  input logic          irq_stat
);
  // R2: a stalled output beat is held
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !srst_on |=> out_valid && $stable(out_pix) && $stable(out_last));

  // R2: consumption yields an output beat on the next cycle
  p_consume_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lyr_ready) |=> out_valid);

  // R12: soft reset flushes the output register
  p_srst_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_on |=> !out_valid);

  // R11: status rises only after a last beat was accepted
  p_status_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(out_valid && out_ready && out_last));

  // R13: when stopped and empty, no output appears
  p_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !out_valid |=> !out_valid);
endmodule

bind layer_compositor lc_checker #(.NL(NL)) u_lc_checker (
  .clk(clk), .rst_n(rst_n), .lyr_ready(lyr_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last),
  .run_en(run_en), .srst_on(srst_on), .irq_stat(irq_stat)
);

// File: tb/test_layer_compositor.sv
module test_layer_compositor;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] lyr_valid = '0;
  logic [NL-1:0] lyr_ready;
  logic [NL*32-1:0] lyr_pix = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_pix;
  logic          out_last;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  int m_ca [NL];
  bit m_aen [NL];
  bit m_pm [NL];
  bit m_cb [NL];
  logic [31:0] m_bg;
  logic [3:0]  m_en;

  layer_compositor #(.NUM_LAYERS(NL)) i_layer_compositor (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lyr_valid(lyr_valid),
    .lyr_ready(lyr_ready), .lyr_pix(lyr_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_layer(input int i, input int ca, input bit aen, input bit pm, input bit cb);
    m_ca[i] = ca; m_aen[i] = aen; m_pm[i] = pm; m_cb[i] = cb;
    wr(8'h40 + 8'(i*8), {22'd0, pm, aen, 8'(ca)});
    wr(8'h44 + 8'(i*8), 32'(cb) << 28);
  endtask

  task automatic set_common(input logic [31:0] bgc, input logic [3:0] en);
    m_bg = bgc; m_en = en;
    wr(8'h14, bgc);
    wr(8'h18, 32'(en));
  endtask

  task automatic restart;
    wr(8'h04, 32'd1);
    wr(8'h04, 32'd0);
  endtask

  function automatic int d255(input int x);
    return (x + 127) / 255;
  endfunction

  function automatic logic [31:0] model(input logic [127:0] px);
    int ch [3];
    if (m_bg[31:24] != 8'hFF) return m_bg;
    ch[0] = m_bg[23:16]; ch[1] = m_bg[15:8]; ch[2] = m_bg[7:0];
    for (int i = 0; i < NL; i++) begin
      if (m_en[i]) begin
        int pa, a, s, sp, v;
        pa = m_cb[i] ? 255 : int'(px[i*32+24 +: 8]);
        a  = m_aen[i] ? d255(m_ca[i] * pa) : pa;
        for (int c = 0; c < 3; c++) begin
          s = int'(px[i*32 + 16 - 8*c +: 8]);
          if (m_pm[i]) begin
            sp = m_aen[i] ? d255(s * m_ca[i]) : s;
            v  = sp + d255(ch[c] * (255 - a));
            ch[c] = (v > 255) ? 255 : v;
          end else begin
            ch[c] = d255(s * a + ch[c] * (255 - a));
          end
        end
      end
    end
    return {8'hFF, 8'(ch[0]), 8'(ch[1]), 8'(ch[2])};
  endfunction

  task automatic send_one(input logic [127:0] px, output logic [31:0] op, output logic ol,
                          output logic ov, output logic [3:0] rdy);
    @(negedge clk);
    lyr_pix = px; lyr_valid = '1;
    #1 rdy = lyr_ready;
    @(negedge clk);
    lyr_valid = '0;
    ov = out_valid; op = out_pix; ol = out_last;
  endtask

  task automatic blend_check(input logic [127:0] px, input string tag);
    logic [31:0] op; logic ol, ov; logic [3:0] rdy; logic [31:0] e;
    e = model(px);
    send_one(px, op, ol, ov, rdy);
    check(ov == 1'b1, {tag, " valid"}, 32'(ov), 32'd1);
    check(op == e, tag, op, e);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(out_valid == 0 && irq == 0 && out_last == 0, "R1 outputs", {out_valid, irq, out_last}, 0);
    check(lyr_ready == 0, "R1 ready", 32'(lyr_ready), 0);
    rd(8'h00, d); check(d == 0, "R1 run reg", d, 0);
    rd(8'h14, d); check(d == 0, "R1 bg reg", d, 0);
    rd(8'h40, d); check(d == 0, "R1 layer ctrl", d, 0);
  endtask

  task automatic t_stopped;
    logic [31:0] d;
    wr(8'h10, {16'd4, 16'd4});
    set_layer(0, 255, 0, 0, 0);
    set_common(32'hFF000000, 4'b0001);
    @(negedge clk); lyr_valid = '1; lyr_pix = '1;
    #1 check(lyr_ready == 0, "R13 no consume when stopped", 32'(lyr_ready), 0);
    @(negedge clk);
    check(out_valid == 0, "R13 no output when stopped", 32'(out_valid), 0);
    lyr_valid = '0;
    wr(8'h00, 32'd1);
    rd(8'h00, d); check(d == 1, "R13 run readback", d, 1);
    blend_check({96'd0, 32'h80_40_C0_10}, "R13 runs after enable");
    restart;
  endtask

  task automatic t_coverage;
    set_layer(0, 0, 0, 0, 0);
    set_common(32'hFF_20_40_60, 4'b0001);
    blend_check({96'd0, 32'h80_F0_10_80}, "R4 coverage half");
    blend_check({96'd0, 32'h00_FF_FF_FF}, "R4 coverage clear");
    blend_check({96'd0, 32'h33_01_FE_7F}, "R4 coverage low alpha");
    restart;
  endtask

  task automatic t_premul;
    set_layer(0, 0, 0, 1, 0);
    set_common(32'hFF_FF_80_00, 4'b0001);
    blend_check({96'd0, 32'h40_F0_20_10}, "R5 premult saturate");
    blend_check({96'd0, 32'hC0_30_30_30}, "R5 premult");
    set_layer(0, 128, 1, 1, 0);
    blend_check({96'd0, 32'hFF_C8_64_0A}, "R5 premult with const alpha");
    restart;
  endtask

  task automatic t_const_alpha;
    logic [31:0] d;
    set_layer(0, 128, 1, 0, 0);
    set_common(32'hFF_00_00_00, 4'b0001);
    rd(8'h40, d); check(d == 32'h180, "R6 ctrl readback", d, 32'h180);
    blend_check({96'd0, 32'hC0_FF_80_40}, "R6 const alpha times pixel alpha");
    set_layer(0, 77, 1, 0, 0);
    blend_check({96'd0, 32'hFF_FF_FF_FF}, "R6 const alpha opaque pixel");
    restart;
  endtask

  task automatic t_cblend;
    set_layer(0, 0, 0, 0, 1);
    set_common(32'hFF_10_20_30, 4'b0001);
    blend_check({96'd0, 32'h00_AA_BB_CC}, "R7 const blend ignores alpha");
    set_layer(0, 64, 1, 0, 1);
    blend_check({96'd0, 32'h00_AA_BB_CC}, "R7 const blend with const alpha");
    restart;
  endtask

  task automatic t_order;
    set_layer(0, 0, 0, 0, 0);
    set_layer(1, 0, 0, 0, 0);
    set_common(32'hFF_00_00_00, 4'b0011);
    blend_check({64'd0, 32'hFF_00_00_FF, 32'hFF_FF_00_00}, "R8 top layer wins");
    blend_check({64'd0, 32'h00_00_00_FF, 32'hFF_FF_00_00}, "R8 clear top shows bottom");
    blend_check({64'd0, 32'h80_00_00_FF, 32'h80_FF_00_00}, "R8 ascending order");
    restart;
  endtask

  task automatic t_disabled;
    logic [31:0] op; logic ol, ov; logic [3:0] rdy; logic [127:0] px; logic [31:0] e;
    set_layer(2, 0, 0, 0, 0);
    set_common(32'hFF_10_10_10, 4'b0100);
    px = {32'hFF_77_77_77, 32'h80_00_FF_00, 32'hFF_11_22_33, 32'hFF_FF_FF_FF};
    e = model(px);
    send_one(px, op, ol, ov, rdy);
    check(rdy == 4'b0100, "R3 only enabled layer ready", 32'(rdy), 32'h4);
    check(ov && op == e, "R3 disabled layers ignored", op, e);
    restart;
  endtask

  task automatic t_bg_translucent;
    set_common(32'h80_11_22_33, 4'b0001);
    blend_check({96'd0, 32'hFF_FF_FF_FF}, "R9 translucent background");
    set_common(32'hFF_11_22_33, 4'b0001);
    restart;
  endtask

  task automatic t_backpressure;
    logic [31:0] first, e2;
    set_layer(0, 0, 0, 0, 0);
    set_common(32'hFF_00_00_00, 4'b0001);
    @(negedge clk);
    out_ready = 1'b0; lyr_pix = {96'd0, 32'hFF_12_34_56}; lyr_valid = '1;
    @(negedge clk);
    lyr_pix = {96'd0, 32'hFF_AB_CD_EF};
    first = out_pix;
    check(out_valid == 1 && first == 32'hFF_12_34_56, "R2 first beat", first, 32'hFF123456);
    #1 check(lyr_ready == 0, "R2 no consume while full", 32'(lyr_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1 && out_pix == first, "R2 held under stall", out_pix, first);
    end
    out_ready = 1'b1;
    #1 check(lyr_ready == 4'b0001, "R2 consume on drain", 32'(lyr_ready), 1);
    @(negedge clk);
    lyr_valid = '0;
    e2 = 32'hFF_AB_CD_EF;
    check(out_valid == 1 && out_pix == e2, "R2 next beat", out_pix, e2);
    @(negedge clk);
    check(out_valid == 0, "R2 drained", 32'(out_valid), 0);
    restart;
  endtask

  task automatic t_frame;
    logic [31:0] op, d; logic ol, ov; logic [3:0] rdy;
    wr(8'h10, {16'd2, 16'd3});
    wr(8'h08, 32'h2);
    restart;
    for (int n = 0; n < 6; n++) begin
      send_one({96'd0, 32'hFF_00_00_00}, op, ol, ov, rdy);
      check(ol == (n == 5), "R10 last flag position", 32'(ol), 32'(n == 5));
      @(negedge clk);
      check(irq == (n == 5), "R11 irq after last", 32'(irq), 32'(n == 5));
    end
    rd(8'h0C, d); check(d == 1, "R11 status set", d, 1);
    wr(8'h0C, 32'd1);
    rd(8'h0C, d); check(d == 1, "R11 nonzero write ignored", d, 1);
    wr(8'h0C, 32'd0);
    check(irq == 0, "R11 cleared by zero", 32'(irq), 0);
    wr(8'h08, 32'h0);
    for (int n = 0; n < 6; n++) send_one({96'd0, 32'hFF_00_00_00}, op, ol, ov, rdy);
    @(negedge clk);
    rd(8'h0C, d);
    check(d == 1 && irq == 0, "R11 masked irq", {d[30:0], irq}, 32'h2);
    wr(8'h0C, 32'd0);
  endtask

  task automatic t_srst;
    logic [31:0] op; logic ol, ov; logic [3:0] rdy;
    restart;
    for (int n = 0; n < 2; n++) send_one({96'd0, 32'hFF_00_00_00}, op, ol, ov, rdy);
    wr(8'h04, 32'd1);
    @(negedge clk); lyr_valid = '1;
    #1 check(lyr_ready == 0, "R12 no consume in soft reset", 32'(lyr_ready), 0);
    @(negedge clk); lyr_valid = '0;
    wr(8'h04, 32'd0);
    for (int n = 0; n < 6; n++) begin
      send_one({96'd0, 32'hFF_00_00_00}, op, ol, ov, rdy);
      if (n == 3 || n == 5)
        check(ol == (n == 5), "R12 frame restarts at origin", 32'(ol), 32'(n == 5));
    end
    @(negedge clk);
    out_ready = 1'b0;
    send_one({96'd0, 32'hFF_00_00_00}, op, ol, ov, rdy);
    check(ov == 1, "R12 beat pending", 32'(ov), 1);
    wr(8'h04, 32'd1);
    @(negedge clk);
    check(out_valid == 0, "R12 pending beat dropped", 32'(out_valid), 0);
    out_ready = 1'b1;
    wr(8'h04, 32'd0);
    wr(8'h0C, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_stopped;
    t_coverage;
    t_premul;
    t_const_alpha;
    t_cblend;
    t_order;
    t_disabled;
    t_bg_translucent;
    t_backpressure;
    t_frame;
    t_srst;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule